// File: doc/BRIEF.md
# Pipelined Integer Multiplier with Selectable Result Word

This execute-stage block multiplies two 32-bit register operands, or one register operand and a sign-extended 16-bit constant. A two-bit selector picks which 32-bit slice of the 64-bit product is returned. That slice is either the low word or the high word, and the high word has three interpretations: both operands signed, both unsigned, or the first signed and the second unsigned. A single signed 33x33 multiplier covers all four cases. Each operand gets one extra bit on top, filled with its sign bit or with zero depending on the chosen interpretation.

The issuing stage presents an operation together with a one-cycle start strobe. The block accepts a new operation on every cycle, and each accepted operation comes back with a one-cycle done pulse a fixed number of cycles later. The result port keeps its last value between done pulses. Writing the result into a register file is left to the surrounding pipeline.

Top module: `mulhw_unit`

## Requirements
- R1: While reset is asserted, and until the first operation completes, `done` is 0 and `result` is 0.
- R2: A start is accepted when `opcode` is 6'b010000 (register form) or 6'b011000 (immediate form). `done` is high for exactly one cycle, on the third rising edge that follows the edge sampling the accepted start. Starts may be accepted on consecutive cycles.
- R3: Register form with `func[1:0]` = 2'b00 returns bits [31:0] of `ra` times `rb`.
- R4: Register form with `func[1:0]` = 2'b01 returns bits [63:32] of the product with both operands treated as two's-complement signed.
- R5: Register form with `func[1:0]` = 2'b11 returns bits [63:32] of the product with both operands treated as unsigned.
- R6: Register form with `func[1:0]` = 2'b10 returns bits [63:32] of the product with `ra` treated as signed and `rb` as unsigned.
- R7: Immediate form returns bits [31:0] of `ra` times `imm` sign-extended from bit 15. `func` and `rb` are ignored.
- R8: A start with any other opcode produces no `done` pulse and leaves `result` unchanged.
- R9: `result` changes only on an edge that also raises `done`.
- R10: `func[10:2]` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start | input | 1 | Operation strobe, one cycle per operation |
| opcode | input | 6 | Operation class: register or immediate multiply |
| func | input | 11 | Function field; bits [1:0] select the result word |
| ra | input | 32 | First operand |
| rb | input | 32 | Second operand (register form) |
| imm | input | 16 | Signed constant (immediate form) |
| result | output | 32 | Selected product word, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
Suppose the selector or a valid bit goes wrong as it travels down the pipe. The port then shows either a done pulse one cycle off or the right word of the wrong operation. With back-to-back issue, the next comparison exposes either fault within three cycles of the start. A wrong extension bit on one operand leaves the low word intact and corrupts only the high word, so the bench drives operands with the top bit set under each of the three high-word selections. Those cases show the fault at the first completion.

// File: rtl/mulhw_pkg.sv
package mulhw_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_MUL_REG = 6'b010000;
  localparam logic [OPC_W-1:0] OPC_MUL_IMM = 6'b011000;

  // Result word selection; the encoding is the low two function bits.
  typedef enum logic [1:0] {
    SEL_LO    = 2'b00,
    SEL_HI_SS = 2'b01,
    SEL_HI_SU = 2'b10,
    SEL_HI_UU = 2'b11
  } word_sel_e;
endpackage

// File: rtl/mulhw_operand_prep.sv
module mulhw_operand_prep
  import mulhw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int FUNC_W = 11,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] ra,
  input  logic [DATA_W-1:0] rb,
  input  logic [IMM_W-1:0]  imm,
  output logic              accept,
  output word_sel_e         sel,
  output logic [EXT_W-1:0]  a_ext,
  output logic [EXT_W-1:0]  b_ext
);
  logic              is_reg;
  logic              is_imm;
  logic [DATA_W-1:0] b_src;
  logic              a_signed;
  logic              b_signed;

  always_comb begin
    is_reg   = (opcode == OPC_MUL_REG);
    is_imm   = (opcode == OPC_MUL_IMM);
    accept   = start & (is_reg | is_imm);
    sel      = is_imm ? SEL_LO : word_sel_e'(func[1:0]);
    b_src    = is_imm ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : rb;
    // The low word is the same under any extension, so SEL_LO takes the signed path.
    a_signed = (sel != SEL_HI_UU);
    b_signed = (sel == SEL_HI_SS) || (sel == SEL_LO);
    a_ext    = {a_signed & ra[DATA_W-1], ra};
    b_ext    = {b_signed & b_src[DATA_W-1], b_src};
  end
endmodule

// File: rtl/mulhw_core.sv
module mulhw_core
  import mulhw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int EXT_W  = DATA_W + 1,
  localparam int PROD_W = 2 * EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  word_sel_e         in_sel,
  input  logic [EXT_W-1:0]  a_ext,
  input  logic [EXT_W-1:0]  b_ext,
  output logic              out_valid,
  output word_sel_e         out_sel,
  output logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] prod_d;

  always_comb begin
    prod_d = PROD_W'($signed(a_ext) * $signed(b_ext));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sel   <= SEL_LO;
      prod      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sel <= in_sel;
        prod    <= prod_d;
      end
    end
  end
endmodule

// File: rtl/mulhw_word_sel.sv
module mulhw_word_sel
  import mulhw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * (DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  word_sel_e         in_sel,
  input  logic [PROD_W-1:0] prod,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] word_d;

  always_comb begin
    if (in_sel == SEL_LO) word_d = prod[DATA_W-1:0];
    else                  word_d = prod[2*DATA_W-1:DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) result <= word_d;
    end
  end
endmodule

// File: rtl/mulhw_unit.sv
module mulhw_unit
  import mulhw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int FUNC_W = 11,
  localparam int EXT_W  = DATA_W + 1,
  localparam int PROD_W = 2 * EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] ra,
  input  logic [DATA_W-1:0] rb,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic             rst_meta_n;
  logic             rst_core_n;
  logic             pre_accept;
  word_sel_e        pre_sel;
  logic [EXT_W-1:0] pre_a;
  logic [EXT_W-1:0] pre_b;
  logic             s1_valid;
  word_sel_e        s1_sel;
  logic [EXT_W-1:0] s1_a;
  logic [EXT_W-1:0] s1_b;
  logic             s2_valid;
  word_sel_e        s2_sel;
  logic [PROD_W-1:0] s2_prod;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  mulhw_operand_prep #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .FUNC_W (FUNC_W)
  ) u_prep (
    .start  (start),
    .opcode (opcode),
    .func   (func),
    .ra     (ra),
    .rb     (rb),
    .imm    (imm),
    .accept (pre_accept),
    .sel    (pre_sel),
    .a_ext  (pre_a),
    .b_ext  (pre_b)
  );

  // Stage 1: capture extended operands.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_valid <= 1'b0;
      s1_sel   <= SEL_LO;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= pre_accept;
      if (pre_accept) begin
        s1_sel <= pre_sel;
        s1_a   <= pre_a;
        s1_b   <= pre_b;
      end
    end
  end

  mulhw_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (s1_valid),
    .in_sel    (s1_sel),
    .a_ext     (s1_a),
    .b_ext     (s1_b),
    .out_valid (s2_valid),
    .out_sel   (s2_sel),
    .prod      (s2_prod)
  );

  mulhw_word_sel #(
    .DATA_W (DATA_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_valid (s2_valid),
    .in_sel   (s2_sel),
    .prod     (s2_prod),
    .done     (done),
    .result   (result)
  );
endmodule

// File: rtl/mulhw_unit_chk.sv
module mulhw_unit_chk
  import mulhw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int FUNC_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [OPC_W-1:0]  opcode,
  input logic [FUNC_W-1:0] func,
  input logic [DATA_W-1:0] ra,
  input logic [DATA_W-1:0] rb,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] result,
  input logic              done
);
  logic known_op;
  assign known_op = (opcode == OPC_MUL_REG) || (opcode == OPC_MUL_IMM);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && known_op) |=> ##2 done);

  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start && known_op, 3));

  // R8
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !known_op) |=> ##2 !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R3
  zero_ra_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode == OPC_MUL_REG && func[1:0] == 2'b00 && ra == '0) |=> ##2 (result == '0));

  // R7
  zero_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode == OPC_MUL_IMM && imm == '0) |=> ##2 (result == '0));
endmodule

bind mulhw_unit mulhw_unit_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .FUNC_W (FUNC_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .opcode (opcode),
  .func   (func),
  .ra     (ra),
  .rb     (rb),
  .imm    (imm),
  .result (result),
  .done   (done)
);

// File: tb/test_mulhw_unit.sv
module test_mulhw_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [5:0]  opcode;
  logic [10:0] func;
  logic [31:0] ra;
  logic [31:0] rb;
  logic [15:0] imm;
  logic [31:0] result;
  logic        done;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    checking = 0;
  bit    finished = 0;
  string cur_tag  = "R3";

  mulhw_unit i_mulhw_unit (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opcode (opcode),
    .func   (func),
    .ra     (ra),
    .rb     (rb),
    .imm    (imm),
    .result (result),
    .done   (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_mul(logic [5:0] op, logic [10:0] fn,
                                          logic [31:0] a, logic [31:0] b, logic [15:0] im);
    logic [63:0] p;
    if (op == 6'b011000) begin
      p = 64'(longint'($signed(a)) * longint'($signed(im)));
      return p[31:0];
    end
    case (fn[1:0])
      2'b00: begin p = {32'h0, a} * {32'h0, b}; return p[31:0]; end
      2'b01: begin p = 64'(longint'($signed(a)) * longint'($signed(b))); return p[63:32]; end
      2'b11: begin p = {32'h0, a} * {32'h0, b}; return p[63:32]; end
      default: begin p = 64'(longint'($signed(a)) * longint'({32'h0, b})); return p[63:32]; end
    endcase
  endfunction

  // Reference pipeline: behavioural queue of pending completions.
  logic [31:0] q_data [3];
  bit          q_vld  [3];
  string       q_tag  [3];
  bit          bad_seen [3];
  logic [31:0] m_result;
  bit          m_done;
  string       m_tag;
  bit          m_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin q_vld[i] = 0; q_data[i] = '0; bad_seen[i] = 0; end
      m_result = '0; m_done = 0; m_tag = "R1"; m_bad = 0;
    end else begin
      m_done = q_vld[1];
      m_bad  = bad_seen[1];
      if (q_vld[1]) begin m_result = q_data[1]; m_tag = q_tag[1]; end
      else m_tag = "R9";
      q_vld[1] = q_vld[0]; q_data[1] = q_data[0]; q_tag[1] = q_tag[0]; bad_seen[1] = bad_seen[0];
      q_vld[0] = start && (opcode == 6'b010000 || opcode == 6'b011000);
      bad_seen[0] = start && !q_vld[0];
      q_data[0] = ref_mul(opcode, func, ra, rb, imm);
      q_tag[0]  = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_checks++;
      if (done !== m_done) begin
        n_fail++;
        $display("FAIL %s done=%0b expected %0b", m_bad ? "R8" : "R2", done, m_done);
      end
      n_checks++;
      if (result !== m_result) begin
        n_fail++;
        $display("FAIL %s result=%h expected %h", m_tag, result, m_result);
      end
    end
  end

  task automatic drive(bit st, logic [5:0] op, logic [10:0] fn, logic [31:0] a,
                       logic [31:0] b, logic [15:0] im, string tag);
    start = st; opcode = op; func = fn; ra = a; rb = b; imm = im; cur_tag = tag;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 6'b010000, '0, '0, '0, '0, "R9");
  endtask

  initial begin
    rst_n = 0; start = 0; opcode = '0; func = '0; ra = '0; rb = '0; imm = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_checks++;
    if (done !== 1'b0 || result !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 done=%0b result=%h expected 0 and 0", done, result);
    end
    rst_n = 1;
    idle(4);
    checking = 1;
    idle(2);
    // R3 low word
    drive(1, 6'b010000, 11'h000, 32'd7, 32'hFFFF_FFFD, '0, "R3");
    drive(1, 6'b010000, 11'h000, 32'hDEAD_BEEF, 32'h1234_5678, '0, "R3");
    // R4 signed high
    drive(1, 6'b010000, 11'h001, 32'hFFFF_FFFE, 32'd3, '0, "R4");
    drive(1, 6'b010000, 11'h001, 32'h8000_0000, 32'h8000_0000, '0, "R4");
    // R5 unsigned high
    drive(1, 6'b010000, 11'h003, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R5");
    // R6 mixed high
    drive(1, 6'b010000, 11'h002, 32'hFFFF_FFFF, 32'hFFFF_FFFF, '0, "R6");
    drive(1, 6'b010000, 11'h002, 32'd2, 32'h8000_0000, '0, "R6");
    // R7 immediate, func and rb ignored
    drive(1, 6'b011000, 11'h7FF, 32'd5, 32'hAAAA_5555, 16'hFFFF, "R7");
    drive(1, 6'b011000, 11'h003, 32'h8000_0001, 32'h1, 16'h7FFF, "R7");
    idle(4);
    // R8 unknown opcodes
    drive(1, 6'b000000, 11'h001, 32'h1234, 32'h5678, 16'h1, "R8");
    drive(1, 6'b010001, 11'h000, 32'h3, 32'h4, 16'h2, "R8");
    idle(4);
    // R10 upper function bits
    drive(1, 6'b010000, 11'h7FD, 32'h8765_4321, 32'hF000_0001, '0, "R10");
    drive(1, 6'b010000, 11'h6A0, 32'h0001_0003, 32'h0002_0005, '0, "R10");
    idle(3);
    // R2 random traffic with back-to-back issue
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      int pick;
      pick = $urandom_range(0, 9);
      op = (pick < 5) ? 6'b010000 : (pick < 8) ? 6'b011000 : 6'($urandom);
      drive(1'($urandom_range(0, 3) != 0), op, 11'($urandom), $urandom, $urandom,
            16'($urandom), "R2");
    end
    idle(5);
    finished = 1;
    checking = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, actual hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule